// File: doc/BRIEF.md
# First-Free Receive Mailbox Allocator

This block holds a bank of receive mailboxes that take complete frames from a CAN receive engine. Each accepted frame arrives as one parallel strobe that carries the identifier, the identifier format, the remote flag, the length code and 64 data bits. The frame is placed in the lowest-numbered mailbox that is empty. The slot stays occupied until software releases it. Because allocation always restarts the scan at mailbox 0, software can read the low mailboxes in index order. It then frees all of them with one mask write while the upper mailboxes catch any traffic that arrives in the meantime.

The highest mailbox is the overflow slot. If every mailbox is occupied and overwrite is enabled, a new frame replaces the contents of that slot and sets a sticky lost-frame flag. If overwrite is disabled, the frame is discarded and a saturating discard counter advances. Software selects a mailbox with a read index. One cycle later it sees that mailbox's identifier word, status word and data. A per-mailbox ready vector shows at a glance which slots hold frames.

Top module: `rx_mailbox_alloc`

## Requirements
- R1: After a synchronous reset, `ready_vec` and `drop_cnt` are zero, and the readout of every mailbox returns zero identifier word, status word and data.
- R2: An accepted frame is stored in the lowest-indexed mailbox whose ready bit is clear, counting the overflow slot as the highest index.
- R3: A filled mailbox keeps its contents and its ready bit until it is re-armed, so later frames move on to the next free mailbox.
- R4: When mailboxes 0 to NUM_MB-2 are all full and the highest mailbox is empty, a frame goes to the highest mailbox, and its lost-frame flag stays clear, whatever the value of `ovr_en`.
- R5: When all mailboxes are full and `ovr_en` is 1, the frame overwrites the highest mailbox, that mailbox stays ready, and its lost-frame flag (status bit 24) becomes 1.
- R6: When all mailboxes are full and `ovr_en` is 0, the frame is discarded, no mailbox content changes, and `drop_cnt` increases by one, holding at its all-ones value.
- R7: A cycle with `rearm_we` high clears the ready bit and lost-frame flag of every mailbox whose bit is 1 in `rearm_mask`. Mailboxes whose mask bit is 0 are not affected. A re-armed mailbox reads back as all zero.
- R8: A mailbox re-armed in the same cycle as an incoming frame counts as free for that frame.
- R9: The status word read for a ready mailbox holds the length in bits 19:16, the remote flag in bit 20, ready in bit 23 and lost-frame in bit 24, with all other bits zero. It appears one cycle after `rd_sel` is applied. An empty or out-of-range selection reads as zero.
- R10: The identifier word holds a standard identifier in bits 28:18 with bit 29 clear, or a 29-bit extended identifier in bits 28:0 with bit 29 set.
- R11: The data output returns the 64 data bits exactly as stored for the selected mailbox.
- R12: Bit i of `ready_vec` is 1 exactly when mailbox i holds an unreleased frame, updated on the clock edge that stores or re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_en | input | 1 | Allow the highest mailbox to be overwritten when all are full |
| rx_valid | input | 1 | One-cycle strobe: a complete frame is presented |
| rx_ext | input | 1 | Frame uses a 29-bit identifier |
| rx_rtr | input | 1 | Frame is a remote request |
| rx_len | input | 4 | Length code |
| rx_id | input | 29 | Identifier (standard uses bits 10:0) |
| rx_data | input | DATA_W | Payload bits |
| rearm_we | input | 1 | Apply `rearm_mask` this cycle |
| rearm_mask | input | NUM_MB | One bit per mailbox to release |
| rd_sel | input | IDX_W | Mailbox index to read out |
| ready_vec | output | NUM_MB | Per-mailbox occupied flags |
| rd_id_word | output | 32 | Formatted identifier of selected mailbox |
| rd_status | output | 32 | Status word of selected mailbox |
| rd_data | output | DATA_W | Payload of selected mailbox |
| drop_cnt | output | DROP_W | Saturating count of discarded frames |

## Verification
A wrong occupancy bit shows up on the same edge in `ready_vec`. It shows up one frame later as a frame landing in the wrong index or being discarded too early. A stale lost-frame flag or an unreleased slot becomes visible in the status word one cycle after that mailbox is selected. Payload or identifier words written to the wrong slot are caught the first time the expected slot is read back after each store, because every stored frame is read back at its predicted index. The overwrite, discard and saturation paths are reached only with every slot full, so the bench fills the bank completely before exercising them.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam int unsigned ID_W          = 29;
  localparam int unsigned LEN_W         = 4;
  localparam int unsigned STD_ID_W      = 11;
  localparam int unsigned STD_SHIFT     = 18;
  localparam int unsigned ID_EXT_BIT    = 29;
  localparam int unsigned ST_LEN_LSB    = 16;
  localparam int unsigned ST_RTR_BIT    = 20;
  localparam int unsigned ST_READY_BIT  = 23;
  localparam int unsigned ST_MISSED_BIT = 24;

  function automatic logic [31:0] make_id_word(input logic ext, input logic [ID_W-1:0] id);
    logic [31:0] w;
    w = '0;
    if (ext) begin
      w[ID_W-1:0]   = id;
      w[ID_EXT_BIT] = 1'b1;
    end else begin
      w[STD_SHIFT +: STD_ID_W] = id[STD_ID_W-1:0];
    end
    return w;
  endfunction

  function automatic logic [31:0] make_status(input logic missed, input logic ready,
                                              input logic rtr, input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[ST_LEN_LSB +: LEN_W] = len;
    w[ST_RTR_BIT]          = rtr;
    w[ST_READY_BIT]        = ready;
    w[ST_MISSED_BIT]       = missed;
    return w;
  endfunction
endpackage

// File: rtl/rxmb_first_free.sv
module rxmb_first_free #(
  parameter int unsigned N     = 12,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     free_vec,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             found
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = free_vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | free_vec[i];
  end

  assign found = seen[N];

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) grant_idx = grant_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store #(
  parameter int unsigned N     = 12,
  parameter int unsigned W     = 99,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxmb_status.sv
module rxmb_status #(
  parameter int unsigned N      = 12,
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      clear_mask,
  input  logic [N-1:0]      set_mask,
  input  logic              ovr_set,
  input  logic              drop,
  output logic [N-1:0]      full,
  output logic [N-1:0]      missed,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int unsigned LAST = N - 1;
  localparam logic [N-1:0] LAST_BIT = N'(1) << LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= '0;
      missed   <= '0;
      drop_cnt <= '0;
    end else begin
      full   <= (full & ~clear_mask) | set_mask;
      missed <= (missed & ~clear_mask) | (ovr_set ? LAST_BIT : '0);
      if (drop && (drop_cnt != {DROP_W{1'b1}})) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  p_fill_sets_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((full & $past(set_mask)) == $past(set_mask)));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (clear_mask == '0) |=> ((full & $past(full)) == $past(full)));

  p_rearm_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (|clear_mask) |=> ((full & $past(clear_mask) & ~$past(set_mask)) == '0));

  p_missed_only_full_r5: assert property (@(posedge clk) disable iff (rst)
    ((missed & ~full) == '0));

  p_drop_step_r6: assert property (@(posedge clk) disable iff (rst)
    (drop && (drop_cnt != {DROP_W{1'b1}})) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

  p_drop_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !drop |=> $stable(drop_cnt));
endmodule

// File: rtl/rx_mailbox_alloc.sv
module rx_mailbox_alloc #(
  parameter int unsigned NUM_MB = 12,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DROP_W = 8,
  localparam int unsigned IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ovr_en,
  input  logic                 rx_valid,
  input  logic                 rx_ext,
  input  logic                 rx_rtr,
  input  logic [3:0]           rx_len,
  input  logic [28:0]          rx_id,
  input  logic [DATA_W-1:0]    rx_data,
  input  logic                 rearm_we,
  input  logic [NUM_MB-1:0]    rearm_mask,
  input  logic [IDX_W-1:0]     rd_sel,
  output logic [NUM_MB-1:0]    ready_vec,
  output logic [31:0]          rd_id_word,
  output logic [31:0]          rd_status,
  output logic [DATA_W-1:0]    rd_data,
  output logic [DROP_W-1:0]    drop_cnt
);
  import rxmb_pkg::*;

  localparam int unsigned LAST   = NUM_MB - 1;
  localparam int unsigned WORD_W = 2 + LEN_W + ID_W + DATA_W;
  localparam logic [NUM_MB-1:0] LAST_BIT = NUM_MB'(1) << LAST;

  logic [NUM_MB-1:0] full_q, missed_q;
  logic [NUM_MB-1:0] clear_vec, free_vec, grant, set_vec;
  logic [IDX_W-1:0]  grant_idx, wr_idx, rd_addr;
  logic              grant_found, ovr_hit, drop, wr_en, sel_ok;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              rd_ok_q, rd_missed_q;

  assign clear_vec = rearm_we ? rearm_mask : '0;
  assign free_vec  = ~(full_q & ~clear_vec);

  rxmb_first_free #(.N(NUM_MB), .IDX_W(IDX_W)) u_pick (
    .free_vec  (free_vec),
    .grant     (grant),
    .grant_idx (grant_idx),
    .found     (grant_found)
  );

  assign ovr_hit = rx_valid && !grant_found && ovr_en;
  assign drop    = rx_valid && !grant_found && !ovr_en;
  assign wr_en   = rx_valid && (grant_found || ovr_en);
  assign wr_idx  = grant_found ? grant_idx : IDX_W'(LAST);
  assign set_vec = !rx_valid ? '0 : (grant_found ? grant : (ovr_hit ? LAST_BIT : '0));
  assign wr_word = {rx_ext, rx_rtr, rx_len, rx_id, rx_data};

  rxmb_status #(.N(NUM_MB), .DROP_W(DROP_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .clear_mask (clear_vec),
    .set_mask   (set_vec),
    .ovr_set    (ovr_hit),
    .drop       (drop),
    .full       (full_q),
    .missed     (missed_q),
    .drop_cnt   (drop_cnt)
  );

  assign sel_ok  = (int'(rd_sel) < NUM_MB);
  assign rd_addr = sel_ok ? rd_sel : '0;

  rxmb_store #(.N(NUM_MB), .W(WORD_W), .IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_word),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q     <= 1'b0;
      rd_missed_q <= 1'b0;
    end else begin
      rd_ok_q     <= sel_ok && full_q[rd_addr];
      rd_missed_q <= sel_ok && missed_q[rd_addr];
    end
  end

  logic              f_ext, f_rtr;
  logic [LEN_W-1:0]  f_len;
  logic [ID_W-1:0]   f_id;
  logic [DATA_W-1:0] f_data;
  assign {f_ext, f_rtr, f_len, f_id, f_data} = rd_word;

  assign ready_vec  = full_q;
  assign rd_id_word = rd_ok_q ? make_id_word(f_ext, f_id) : '0;
  assign rd_status  = rd_ok_q ? make_status(rd_missed_q, 1'b1, f_rtr, f_len) : '0;
  assign rd_data    = rd_ok_q ? f_data : '0;

  p_grant_is_free_r2: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~free_vec) == '0));

  p_grant_single_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_overwrite_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    ovr_hit |-> full_q[LAST]);

  p_ready_tracks_store_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ready_vec[$past(wr_idx)]);
endmodule

// File: tb/rx_mailbox_alloc_bench.sv
module rx_mailbox_alloc_bench;
  localparam int unsigned N = 12;
  localparam int unsigned DW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ovr_en, rx_valid, rx_ext, rx_rtr, rearm_we;
  logic [3:0] rx_len, rd_sel;
  logic [28:0] rx_id;
  logic [DW-1:0] rx_data, rd_data;
  logic [N-1:0] rearm_mask, ready_vec;
  logic [31:0] rd_id_word, rd_status;
  logic [7:0] drop_cnt;

  rx_mailbox_alloc u_rx_mailbox_alloc (
    .clk(clk), .rst(rst), .ovr_en(ovr_en), .rx_valid(rx_valid), .rx_ext(rx_ext),
    .rx_rtr(rx_rtr), .rx_len(rx_len), .rx_id(rx_id), .rx_data(rx_data),
    .rearm_we(rearm_we), .rearm_mask(rearm_mask), .rd_sel(rd_sel),
    .ready_vec(ready_vec), .rd_id_word(rd_id_word), .rd_status(rd_status),
    .rd_data(rd_data), .drop_cnt(drop_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // {rearm mask, ext, rtr, len, id, expected mailbox}
  localparam logic [50:0] VEC [16] = '{
    {12'h000, 1'b0, 1'b0, 4'd8, 29'h123,      4'd0},
    {12'h000, 1'b1, 1'b1, 4'd0, 29'h1ABCDEF0, 4'd1},
    {12'h000, 1'b0, 1'b0, 4'd4, 29'h7FF,      4'd2},
    {12'h000, 1'b0, 1'b1, 4'd2, 29'h055,      4'd3},
    {12'h002, 1'b1, 1'b0, 4'd8, 29'h0000001,  4'd1},  // R8: freed in same cycle
    {12'h000, 1'b0, 1'b0, 4'd1, 29'h400,      4'd4},
    {12'h000, 1'b1, 1'b0, 4'd7, 29'h1FFFFFFF, 4'd5},
    {12'h000, 1'b0, 1'b0, 4'd3, 29'h001,      4'd6},
    {12'h000, 1'b0, 1'b0, 4'd5, 29'h3C3,      4'd7},
    {12'h000, 1'b1, 1'b0, 4'd6, 29'h0ABCDE,   4'd8},
    {12'h000, 1'b0, 1'b0, 4'd8, 29'h2AA,      4'd9},
    {12'h000, 1'b0, 1'b1, 4'd1, 29'h111,      4'd10},
    {12'h000, 1'b0, 1'b0, 4'd8, 29'h7EE,      4'd11}, // R4
    {12'h0FF, 1'b0, 1'b0, 4'd2, 29'h0F0,      4'd0},
    {12'h000, 1'b1, 1'b0, 4'd8, 29'h12345,    4'd1},
    {12'h800, 1'b0, 1'b1, 4'd3, 29'h321,      4'd2}
  };

  function automatic logic [63:0] data_of(input int i);
    return {32'hDA7A_0000 + 32'(i), 32'h0BAD_F000 + 32'(i * 3)};
  endfunction

  function automatic logic [31:0] exp_id(input logic e, input logic [28:0] id);
    if (e) return 32'h2000_0000 | {3'b000, id};
    return {21'b0, id[10:0]} << 18;
  endfunction

  function automatic logic [31:0] exp_sts(input logic m, input logic r, input logic t, input logic [3:0] l);
    return (32'(m) << 24) | (32'(r) << 23) | (32'(t) << 20) | (32'(l) << 16);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [N-1:0] m, input logic e, input logic t,
                       input logic [3:0] l, input logic [28:0] id, input logic [63:0] d);
    rx_valid = v; rearm_we = |m; rearm_mask = m;
    rx_ext = e; rx_rtr = t; rx_len = l; rx_id = id; rx_data = d;
    @(negedge clk);
    rx_valid = 0; rearm_we = 0; rearm_mask = '0;
  endtask

  task automatic read_mb(input logic [3:0] s);
    rd_sel = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_ready;
    rst = 1; ovr_en = 1; rx_valid = 0; rx_ext = 0; rx_rtr = 0; rx_len = 0; rx_id = 0;
    rx_data = 0; rearm_we = 0; rearm_mask = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ready_vec", 64'(ready_vec), 64'h0);
    check("R1 drop_cnt", 64'(drop_cnt), 64'h0);
    read_mb(0);
    check("R1 status", 64'(rd_status), 64'h0);
    check("R1 id", 64'(rd_id_word), 64'h0);
    check("R1 data", rd_data, 64'h0);

    exp_ready = '0;
    for (int i = 0; i < 16; i++) begin
      logic [50:0] v;
      v = VEC[i];
      drive(1'b1, v[50:39], v[38], v[37], v[36:33], v[32:4], data_of(i));
      exp_ready = (exp_ready & ~v[50:39]) | (N'(1) << v[3:0]);
      check("R2 R3 R8 R12 ready_vec", 64'(ready_vec), 64'(exp_ready));
      read_mb(v[3:0]);
      check("R10 id word", 64'(rd_id_word), 64'(exp_id(v[38], v[32:4])));
      check("R9 status", 64'(rd_status), 64'(exp_sts(1'b0, 1'b1, v[37], v[36:33])));
      check("R11 data", rd_data, data_of(i));
    end

    // fill remaining slots 3..7 then 11 (R2, R4)
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, '0, 1'b0, 1'b0, 4'd1, 29'(k), data_of(40 + k));
      exp_ready = exp_ready | (N'(1) << ((k < 5) ? (k + 3) : 11));
      check("R4 fill ready_vec", 64'(ready_vec), 64'(exp_ready));
    end
    check("R3 all full", 64'(ready_vec), 64'hFFF);

    // overwrite of last slot (R5)
    ovr_en = 1;
    drive(1'b1, '0, 1'b1, 1'b1, 4'd6, 29'h0DEADBE, 64'hFEED_FACE_CAFE_BEEF);
    check("R5 ready kept", 64'(ready_vec), 64'hFFF);
    read_mb(11);
    check("R5 status missed", 64'(rd_status), 64'(exp_sts(1'b1, 1'b1, 1'b1, 4'd6)));
    check("R5 id", 64'(rd_id_word), 64'(exp_id(1'b1, 29'h0DEADBE)));
    check("R5 data", rd_data, 64'hFEED_FACE_CAFE_BEEF);
    check("R5 no drop", 64'(drop_cnt), 64'h0);

    // discard when overwrite off (R6)
    ovr_en = 0;
    drive(1'b1, '0, 1'b0, 1'b0, 4'd2, 29'h015, 64'h1111_2222_3333_4444);
    check("R6 drop count", 64'(drop_cnt), 64'h1);
    read_mb(11);
    check("R6 data unchanged", rd_data, 64'hFEED_FACE_CAFE_BEEF);
    check("R6 status unchanged", 64'(rd_status), 64'(exp_sts(1'b1, 1'b1, 1'b1, 4'd6)));
    read_mb(0);
    check("R6 slot0 unchanged", rd_data, data_of(13));

    // single re-arm of last slot (R7)
    drive(1'b0, 12'h800, 1'b0, 1'b0, 4'd0, 29'h0, 64'h0);
    check("R7 ready_vec", 64'(ready_vec), 64'h7FF);
    read_mb(11);
    check("R7 cleared status", 64'(rd_status), 64'h0);
    read_mb(3);
    check("R7 untouched slot", 64'(rd_status), 64'(exp_sts(1'b0, 1'b1, 1'b0, 4'd1)));

    // last slot empty, overwrite off: frame still lands there (R4)
    drive(1'b1, '0, 1'b0, 1'b0, 4'd5, 29'h2B, 64'h5555_6666_7777_8888);
    check("R4 ready_vec", 64'(ready_vec), 64'hFFF);
    read_mb(11);
    check("R4 status no missed", 64'(rd_status), 64'(exp_sts(1'b0, 1'b1, 1'b0, 4'd5)));
    check("R4 data", rd_data, 64'h5555_6666_7777_8888);

    // saturation of discard counter (R6)
    for (int k = 0; k < 300; k++)
      drive(1'b1, '0, 1'b0, 1'b0, 4'd1, 29'h7, 64'h0);
    check("R6 saturate", 64'(drop_cnt), 64'hFF);

    // out-of-range selection (R9)
    read_mb(4'd12);
    check("R9 out of range status", 64'(rd_status), 64'h0);
    check("R9 out of range data", rd_data, 64'h0);

    // bulk re-arm (R7, R12)
    drive(1'b0, 12'hFFF, 1'b0, 1'b0, 4'd0, 29'h0, 64'h0);
    check("R7 R12 all released", 64'(ready_vec), 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule